// File: doc/BRIEF.md
# Audio Serial Sample Deserializer

This block takes the serial data line of an audio converter running in a DSP-style frame and turns it into a 16-bit parallel sample. It runs on the fast system clock. It does not see the bit clock itself. A one-cycle enable, `bit_en_i`, marks each falling edge of the bit clock, and the block samples the serial line only in those cycles.

A frame lasts 64 bit-clock periods. It opens with a frame-start strobe that is high for one bit-clock period, so exactly one enable sees the strobe high. That enable arms the block. The bit on the line in that slot is not part of the sample. The next 16 enables deliver the sample MSB first. After the 16th bit the block presents the word and raises `valid_o` for one system-clock cycle. It then ignores the rest of the frame until the next strobe.

Top module: `audio_sample_deser`

## Requirements
- R1: The 16 bits sampled on the 16 enables after the start slot form `sample_o`, and the first of them lands in bit 15 (MSB first).
- R2: `valid_o` is high for exactly one system-clock cycle, in the cycle after the clock edge that samples the 16th bit. `sample_o` takes its new value at that same edge.
- R3: Capture begins only at an enable cycle in which `frame_start_i` is high, and the data on that cycle is discarded. Enables seen before any start produce no valid pulse.
- R4: Bits are taken only in cycles where `bit_en_i` is high. The serial line and a start strobe in cycles without the enable have no effect.
- R5: Once 16 bits are captured, further enables in the same frame produce no valid pulse and leave `sample_o` unchanged, until the next start.
- R6: `sample_o` holds its value between valid pulses.
- R7: An asynchronous active-low reset `rst_ni` clears the bit counter, drives `valid_o` low and drives `sample_o` to zero. After reset the block waits for a start.
- R8: A start seen during a capture discards the partial sample and restarts the bit count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame-start strobe, high for one bit-clock period |
| bit_en_i | input | 1 | One-cycle enable marking a falling edge of the bit clock |
| ser_dat_i | input | 1 | Serial data from the converter |
| sample_o | output | 16 | Last complete sample |
| valid_o | output | 1 | One-cycle pulse when a new sample is on `sample_o` |

## Verification
Two conditions are hardest to reach from the ports, because a normal frame never produces them: a start strobe that arrives while a capture is half done, and a reset that lands mid-capture.

The bench reaches both with directed sequences:
- It sends a start followed by eight bits and then a fresh full frame. Only the second word may appear, with a single valid pulse.
- It asserts reset after five bits, then feeds enables without a start. No word may appear.

Between enables the bench drives the inverse of each bit onto the serial line, so any sampling outside the enable corrupts the word.

// File: rtl/asd_pkg.sv
package asd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } asd_state_e;
endpackage

// File: rtl/asd_ctrl.sv
module asd_ctrl
  import asd_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_en_i,
  output logic shift_en_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);

  asd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (bit_en_i) begin
      if (start_i) begin
        // sync slot: arm or re-arm, slot data is not part of the sample
        state_q <= ST_CAPT;
        cnt_q   <= '0;
      end else if (state_q == ST_CAPT) begin
        if (cnt_q == LAST_IDX) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    shift_en_o = bit_en_i && !start_i && (state_q == ST_CAPT);
    last_o     = shift_en_o && (cnt_q == LAST_IDX);
  end
endmodule

// File: rtl/asd_shift.sv
module asd_shift #(
  parameter int SAMPLE_W  = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                last_i,
  input  logic                dat_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                valid_o
);
  localparam int HIST_W = SAMPLE_W - 1;

  // only the bits before the final one need storing
  logic [HIST_W-1:0]   hist_q, hist_d;
  logic [SAMPLE_W-1:0] full_word;

  generate
    if (MSB_FIRST) begin : g_msb
      assign hist_d    = {hist_q[HIST_W-2:0], dat_i};
      assign full_word = {hist_q, dat_i};
    end else begin : g_lsb
      assign hist_d    = {dat_i, hist_q[HIST_W-1:1]};
      assign full_word = {dat_i, hist_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_i;
      if (shift_en_i) hist_q <= hist_d;
      if (last_i)     word_o <= full_word;
    end
  end
endmodule

// File: rtl/audio_sample_deser.sv
module audio_sample_deser #(
  parameter int SAMPLE_W  = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                bit_en_i,
  input  logic                ser_dat_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  logic shift_en;
  logic last_bit;

  asd_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (frame_start_i),
    .bit_en_i   (bit_en_i),
    .shift_en_o (shift_en),
    .last_o     (last_bit)
  );

  asd_shift #(.SAMPLE_W(SAMPLE_W), .MSB_FIRST(MSB_FIRST)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .last_i     (last_bit),
    .dat_i      (ser_dat_i),
    .word_o     (sample_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/asd_checker.sv
module asd_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_start_i,
  input logic                bit_en_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                valid_o
);
  localparam int CW = $clog2(SAMPLE_W + 2);
  localparam logic [CW-1:0] IDLE_V = CW'(SAMPLE_W + 1);

  // data enables since the last start; IDLE_V means saturated or no start yet
  logic [CW-1:0] bits_q;
  logic          seen_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q       <= IDLE_V;
      seen_valid_q <= 1'b0;
    end else begin
      if (bit_en_i && frame_start_i)  bits_q <= '0;
      else if (bit_en_i && bits_q < IDLE_V) bits_q <= bits_q + 1'b1;
      if (bit_en_i && frame_start_i)  seen_valid_q <= 1'b0;
      else if (valid_o)               seen_valid_q <= 1'b1;
    end
  end

  // R1, R3, R8: a pulse only after exactly 16 data enables since a start
  p_bit_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (bits_q == CW'(SAMPLE_W)));

  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_on_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i && !frame_start_i));

  p_one_per_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !seen_valid_q);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_o) |-> valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r7: assert (!valid_o && sample_o == '0)
        else $error("reset state violated");
    end
  end
endmodule

bind audio_sample_deser asd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .bit_en_i      (bit_en_i),
  .sample_o      (sample_o),
  .valid_o       (valid_o)
);

// File: tb/audio_sample_deser_tb.sv
module audio_sample_deser_tb;
  localparam int W = 16;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC_WORD [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                            16'h8001, 16'h7FFE, 16'h1234};
  localparam int VEC_TAIL [NV] = '{47, 0, 3, 47, 10, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, en = 1'b0, sd = 1'b0;
  logic [W-1:0] q;
  logic v;
  int checks = 0, fails = 0, valid_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_sample_deser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .bit_en_i(en),
    .ser_dat_i(sd), .sample_o(q), .valid_o(v)
  );

  always @(posedge clk) if (rst_n && v) valid_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one enable with data d; inverse data on the line between enables (R4)
  task automatic en_cycle(input logic fs_v, input logic d);
    @(negedge clk); fs = fs_v; en = 1'b1; sd = d;
    @(negedge clk); en = 1'b0; fs = 1'b0; sd = ~d;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [W-1:0] word, input int tail);
    int v0;
    v0 = valid_cnt;
    en_cycle(1'b1, 1'b1);
    for (int i = 0; i < W - 1; i++) en_cycle(1'b0, word[W-1-i]);
    chk("R3 no early valid", valid_cnt, v0);
    @(negedge clk); en = 1'b1; sd = word[0];
    @(negedge clk); en = 1'b0; sd = ~word[0];
    chk("R2 valid after 16th bit", v, 1);
    chk("R1 sample word", q, word);
    @(negedge clk);
    chk("R2 valid one cycle", v, 0);
    @(negedge clk);
    chk("R2 single pulse", valid_cnt, v0 + 1);
    for (int i = 0; i < tail; i++) en_cycle(1'b0, i[0] ^ i[2]);
    chk("R5 tail ignored, no valid", valid_cnt, v0 + 1);
    chk("R6 sample held", q, word);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk("R7 reset valid", v, 0);
    chk("R7 reset sample", q, 0);
    rst_n = 1'b1;

    // R3: enables before any start
    for (int i = 0; i < 20; i++) en_cycle(1'b0, 1'b1);
    chk("R3 no start no valid", valid_cnt, 0);
    chk("R3 no start sample", q, 0);

    for (int k = 0; k < NV; k++) send_frame(VEC_WORD[k], VEC_TAIL[k]);

    // R4: strobe without enable must not arm
    v0 = valid_cnt;
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    for (int i = 0; i < W; i++) en_cycle(1'b0, 1'b0);
    chk("R4 strobe without enable", valid_cnt, v0);
    chk("R4 sample untouched", q, VEC_WORD[NV-1]);

    // R8: restart mid-capture
    v0 = valid_cnt;
    en_cycle(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) en_cycle(1'b0, 1'b1);
    send_frame(16'h3C5A, 2);
    chk("R8 restart single valid", valid_cnt, v0 + 1);

    // R7: reset mid-capture
    en_cycle(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) en_cycle(1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R7 mid reset valid", v, 0);
    chk("R7 mid reset sample", q, 0);
    @(negedge clk); rst_n = 1'b1;
    v0 = valid_cnt;
    for (int i = 0; i < 11; i++) en_cycle(1'b0, 1'b1);
    chk("R7 counter cleared", valid_cnt, v0);
    chk("R7 sample stays zero", q, 0);
    send_frame(16'hBEEF, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule